// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches a bank of already-debounced GPIO input lines. For each line it turns level and edge conditions into interrupt events. Each line has four independent detect controls: low level, high level, rising edge and falling edge. They may be combined freely on one line. Detected events latch into a status vector, which software clears by writing ones. A per-line enable vector, with a plain write address plus atomic set and clear alias addresses, masks the status into a single interrupt output.

A separate wake-enable vector produces a wake request. The wake request also covers the case where the block's state is frozen by an active clock-gate input. While that gate is active, a line that changes or holds an active level still raises the wake request without any clock edge. All configuration and status share one simple word-addressed register port with combinational read data.

Top module: `gpioEvtTop`

## Requirements
- R1: After reset the four detect vectors, the status vector, the enable vector and the wake-enable vector read as zero, and irqOut and wakeReq are low.
- R2: Word addresses are: 0 low-level detect, 1 high-level detect, 2 rising-edge detect, 3 falling-edge detect, 4 status, 5 enable (plain write), 6 enable set alias, 7 enable clear alias, 8 wake enable. Read data is combinational for the presented address. Addresses 5, 6 and 7 all read the enable vector. Any other address reads zero, and writes to it change nothing.
- R3: A line with low-level detect set has its status bit set at every clock edge where its input is 0. A line with high-level detect set has its status bit set at every clock edge where its input is 1.
- R4: The block keeps the input value sampled at the previous clock edge, which is 0 out of reset. A rising edge is a 0 sample followed by a 1 at the next edge, and a falling edge is 1 followed by 0. The status bit is set at the edge that first samples the new value, and it stays set after the input settles.
- R5: Any combination of the four detect controls may be active on one line. The events from all active controls are ORed, and a change in a direction whose control is off sets nothing.
- R6: Writing the status address clears each status bit whose written bit is 1. Bits written 0 keep their value.
- R7: When an event and a clear hit the same status bit at the same edge, the bit stays set. A level that persists therefore re-sets its bit right after a clear.
- R8: A write to address 5 loads the enable vector. A write to address 6 sets only the enable bits written 1. A write to address 7 clears only the enable bits written 1.
- R9: irqOut is high exactly when some line has both its status bit and its enable bit set. A status bit that is not enabled stays latched without raising irqOut.
- R10: wakeReq is high when some wake-enabled line has its status bit set or a currently detected event. While gateActive is high, the status vector and the sampled inputs hold their values, and status clear writes have no effect. wakeReq still follows the inputs combinationally during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateActive | input | 1 | Clock gate active: freezes status and input sampling |
| pinIn | input | NUM_PINS | Debounced input lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | NUM_PINS | Register write data |
| regRdData | output | NUM_PINS | Combinational register read data |
| irqOut | output | 1 | Masked interrupt request |
| wakeReq | output | 1 | Wake request |

## Verification
A status bit, and irqOut with it, changes at the first clock edge that samples the triggering input or the clearing write. The bench therefore applies each stimulus between edges, waits exactly one rising edge, and reads status and irqOut 3 ns later, before the next edge can add a level event. Enable and configuration writes are read back the same way one edge after the write. During the gate, wakeReq is checked 1 ns after the input change with no clock edge in between, and the frozen status is checked after two further edges.

// File: rtl/gpioEvtPkg.sv
package gpioEvtPkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LVL_LO  = 4'd0,
    ADDR_LVL_HI  = 4'd1,
    ADDR_RISE    = 4'd2,
    ADDR_FALL    = 4'd3,
    ADDR_STATUS  = 4'd4,
    ADDR_ENABLE  = 4'd5,
    ADDR_EN_SET  = 4'd6,
    ADDR_EN_CLR  = 4'd7,
    ADDR_WAKE_EN = 4'd8
  } regAddrE;

  typedef enum logic [2:0] {
    RD_NONE, RD_LVL_LO, RD_LVL_HI, RD_RISE, RD_FALL, RD_STATUS, RD_ENABLE, RD_WAKE
  } rdSelE;

  typedef struct packed {
    logic  wrLvlLo;
    logic  wrLvlHi;
    logic  wrRise;
    logic  wrFall;
    logic  clrStatus;
    logic  wrEnable;
    logic  setEnable;
    logic  clrEnable;
    logic  wrWake;
    rdSelE rdSel;
  } ctrlStrobesT;

endpackage

// File: rtl/gpioEvtCtrl.sv
module gpioEvtCtrl
  import gpioEvtPkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobesT       strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    case (regAddr)
      ADDR_LVL_LO:  begin strb.wrLvlLo   = regWrEn; strb.rdSel = RD_LVL_LO; end
      ADDR_LVL_HI:  begin strb.wrLvlHi   = regWrEn; strb.rdSel = RD_LVL_HI; end
      ADDR_RISE:    begin strb.wrRise    = regWrEn; strb.rdSel = RD_RISE;   end
      ADDR_FALL:    begin strb.wrFall    = regWrEn; strb.rdSel = RD_FALL;   end
      ADDR_STATUS:  begin strb.clrStatus = regWrEn; strb.rdSel = RD_STATUS; end
      ADDR_ENABLE:  begin strb.wrEnable  = regWrEn; strb.rdSel = RD_ENABLE; end
      ADDR_EN_SET:  begin strb.setEnable = regWrEn; strb.rdSel = RD_ENABLE; end
      ADDR_EN_CLR:  begin strb.clrEnable = regWrEn; strb.rdSel = RD_ENABLE; end
      ADDR_WAKE_EN: begin strb.wrWake    = regWrEn; strb.rdSel = RD_WAKE;   end
      default:      strb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpioEvtPinDetect.sv
module gpioEvtPinDetect (
  input  logic curIn,
  input  logic prevIn,
  input  logic cfgLo,
  input  logic cfgHi,
  input  logic cfgRise,
  input  logic cfgFall,
  output logic evt
);

  logic isRise;
  logic isFall;

  always_comb begin
    isRise = curIn & ~prevIn;
    isFall = ~curIn & prevIn;
    evt    = (cfgLo & ~curIn) | (cfgHi & curIn) | (cfgRise & isRise) | (cfgFall & isFall);
  end

endmodule

// File: rtl/gpioEvtDatapath.sv
module gpioEvtDatapath
  import gpioEvtPkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                gateActive,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctrlStrobesT         strb,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] enableQ,
  output logic [NUM_PINS-1:0] eventVec,
  output logic                irqOut,
  output logic                wakeReq
);

  logic [NUM_PINS-1:0] lvlLoQ;
  logic [NUM_PINS-1:0] lvlHiQ;
  logic [NUM_PINS-1:0] riseQ;
  logic [NUM_PINS-1:0] fallQ;
  logic [NUM_PINS-1:0] wakeEnQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] statusNext;
  logic [NUM_PINS-1:0] enableNext;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlLoQ  <= '0;
      lvlHiQ  <= '0;
      riseQ   <= '0;
      fallQ   <= '0;
      wakeEnQ <= '0;
    end else begin
      if (strb.wrLvlLo) lvlLoQ  <= wrData;
      if (strb.wrLvlHi) lvlHiQ  <= wrData;
      if (strb.wrRise)  riseQ   <= wrData;
      if (strb.wrFall)  fallQ   <= wrData;
      if (strb.wrWake)  wakeEnQ <= wrData;
    end
  end

  // per-line event detection
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    gpioEvtPinDetect u_det (
      .curIn  (pinIn[i]),
      .prevIn (prevQ[i]),
      .cfgLo  (lvlLoQ[i]),
      .cfgHi  (lvlHiQ[i]),
      .cfgRise(riseQ[i]),
      .cfgFall(fallQ[i]),
      .evt    (eventVec[i])
    );
  end

  // status: clear by write-one, new event takes priority
  always_comb begin
    clrMask    = strb.clrStatus ? wrData : '0;
    statusNext = (statusQ & ~clrMask) | eventVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      prevQ   <= '0;
    end else if (!gateActive) begin
      statusQ <= statusNext;
      prevQ   <= pinIn;
    end
  end

  // enable with plain, set and clear access
  always_comb begin
    enableNext = enableQ;
    if (strb.wrEnable)  enableNext = wrData;
    if (strb.setEnable) enableNext = enableQ | wrData;
    if (strb.clrEnable) enableNext = enableQ & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else       enableQ <= enableNext;
  end

  // outputs
  always_comb begin
    irqOut  = |(statusQ & enableQ);
    wakeReq = |((statusQ | eventVec) & wakeEnQ);
  end

  always_comb begin
    case (strb.rdSel)
      RD_LVL_LO: rdData = lvlLoQ;
      RD_LVL_HI: rdData = lvlHiQ;
      RD_RISE:   rdData = riseQ;
      RD_FALL:   rdData = fallQ;
      RD_STATUS: rdData = statusQ;
      RD_ENABLE: rdData = enableQ;
      RD_WAKE:   rdData = wakeEnQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpioEvtTop.sv
module gpioEvtTop
  import gpioEvtPkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                gateActive,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                irqOut,
  output logic                wakeReq
);

  ctrlStrobesT         strb;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] enableVec;
  logic [NUM_PINS-1:0] eventVec;

  gpioEvtCtrl u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strb   (strb)
  );

  gpioEvtDatapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .gateActive(gateActive),
    .pinIn     (pinIn),
    .strb      (strb),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .statusQ   (statusVec),
    .enableQ   (enableVec),
    .eventVec  (eventVec),
    .irqOut    (irqOut),
    .wakeReq   (wakeReq)
  );

endmodule

// File: rtl/gpioEvtChecker.sv
module gpioEvtChecker
  import gpioEvtPkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                gateActive,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_PINS-1:0] regWrData,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] enableVec,
  input logic [NUM_PINS-1:0] eventVec
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (statusVec == '0 && enableVec == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STATUS && !gateActive)
      |=> ((statusVec & $past(regWrData) & ~$past(eventVec)) == '0));

  assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STATUS)
      |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gateActive |=> ((statusVec & $past(eventVec)) == $past(eventVec)));

  assert_set_alias_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_EN_SET)
      |=> (enableVec == ($past(enableVec) | $past(regWrData))));

  assert_clr_alias_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_EN_CLR)
      |=> (enableVec == ($past(enableVec) & ~$past(regWrData))));

  assert_gate_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    gateActive |=> $stable(statusVec));

endmodule

bind gpioEvtTop gpioEvtChecker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gateActive(gateActive),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .statusVec (statusVec),
  .enableVec (enableVec),
  .eventVec  (eventVec)
);

// File: tb/sim_gpioEvtTop.sv
`timescale 1ns/1ps
module sim_gpioEvtTop;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          gateActive = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          regWrEn = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [NP-1:0] regWrData = '0;
  logic [NP-1:0] regRdData;
  logic          irqOut;
  logic          wakeReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  gpioEvtTop #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rstN(rstN), .gateActive(gateActive), .pinIn(pinIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .wakeReq(wakeReq)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [NP-1:0] pins;
    logic [NP-1:0] clr;
    logic [NP-1:0] expStatus;
    logic          expIrq;
  } stepT;

  // detect config: low=bit0, high=bits1,5, rise=bits2,4,5, fall=bits3,4; enable=bits2,3
  localparam stepT STEPS [14] = '{
    '{32'h05, 32'h00, 32'h04, 1'b1},  // R4 rise on line 2
    '{32'h05, 32'h04, 32'h00, 1'b0},  // R6 clear after settle
    '{32'h01, 32'h00, 32'h00, 1'b0},  // R5 fall on rise-only line
    '{32'h11, 32'h00, 32'h10, 1'b0},  // R9 latched but masked
    '{32'h01, 32'h10, 32'h10, 1'b0},  // R7 fall vs clear
    '{32'h09, 32'h10, 32'h00, 1'b0},  // R5 rise on fall-only line
    '{32'h01, 32'h00, 32'h08, 1'b1},  // R4 fall on line 3
    '{32'h00, 32'h08, 32'h01, 1'b0},  // R3 low level
    '{32'h00, 32'h01, 32'h01, 1'b0},  // R7 level persists
    '{32'h01, 32'h01, 32'h00, 1'b0},  // R3 level gone
    '{32'h21, 32'h00, 32'h20, 1'b0},  // R5 high+rise combined
    '{32'h03, 32'h20, 32'h02, 1'b0},  // R3 high level
    '{32'h01, 32'h02, 32'h00, 1'b0},  // R6
    '{32'h01, 32'h00, 32'h00, 1'b0}   // R6 zero write
  };

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #3;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic idle();
    @(posedge clk); #3;
  endtask

  logic [NP-1:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pinIn = 32'h01;
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], v);
      check($sformatf("R1 reg %0d after reset", a), v, '0);
    end
    check("R1 irqOut after reset", {31'b0, irqOut}, '0);
    check("R1 wakeReq after reset", {31'b0, wakeReq}, '0);

    // R2 configuration and map
    wr(4'd0, 32'h01); wr(4'd1, 32'h22); wr(4'd2, 32'h34); wr(4'd3, 32'h18);
    wr(4'd6, 32'h0C);
    rd(4'd0, v); check("R2 low-level readback", v, 32'h01);
    rd(4'd1, v); check("R2 high-level readback", v, 32'h22);
    rd(4'd2, v); check("R2 rise readback", v, 32'h34);
    rd(4'd3, v); check("R2 fall readback", v, 32'h18);
    rd(4'd7, v); check("R2 alias reads enable", v, 32'h0C);
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, v); check("R2 unmapped reads zero", v, '0);
    rd(4'd0, v); check("R2 unmapped write ignored", v, 32'h01);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); check("R6 initial clear", v, '0);

    // table walk
    for (int i = 0; i < 14; i++) begin
      pinIn = STEPS[i].pins;
      wr(4'd4, STEPS[i].clr);
      rd(4'd4, v);
      check($sformatf("R3 R4 R5 R7 table step %0d status", i), v, STEPS[i].expStatus);
      check($sformatf("R9 table step %0d irq", i), {31'b0, irqOut}, {31'b0, STEPS[i].expIrq});
    end

    // R6 zero write keeps a latched bit
    pinIn = 32'h05; idle();
    rd(4'd4, v); check("R4 rise before zero write", v, 32'h04);
    wr(4'd4, 32'h0);
    rd(4'd4, v); check("R6 zero write keeps bit", v, 32'h04);
    wr(4'd4, 32'h04);
    rd(4'd4, v); check("R6 one write clears bit", v, '0);

    // R8 enable access
    wr(4'd5, 32'hF0F0); rd(4'd5, v); check("R8 plain write", v, 32'hF0F0);
    wr(4'd6, 32'h0003); rd(4'd5, v); check("R8 set alias", v, 32'hF0F3);
    wr(4'd7, 32'h00F0); rd(4'd5, v); check("R8 clear alias", v, 32'hF003);
    wr(4'd5, 32'h0C);

    // R10 wake and gating
    wr(4'd8, 32'h04);
    pinIn = 32'h01; idle();
    rd(4'd4, v); check("R10 setup status", v, '0);
    check("R10 wake idle", {31'b0, wakeReq}, '0);
    gateActive = 1'b1; idle();
    pinIn = 32'h05; #1;
    check("R10 wake while gated", {31'b0, wakeReq}, 32'h1);
    wr(4'd4, 32'hFFFF_FFFF); idle();
    rd(4'd4, v); check("R10 status frozen while gated", v, '0);
    check("R10 wake held while gated", {31'b0, wakeReq}, 32'h1);
    gateActive = 1'b0; idle();
    rd(4'd4, v); check("R10 event after ungate", v, 32'h04);
    check("R9 irq after ungate", {31'b0, irqOut}, 32'h1);
    wr(4'd4, 32'h04);
    check("R10 wake drops after clear", {31'b0, wakeReq}, '0);
    pinIn = 32'h15; idle();
    rd(4'd4, v); check("R4 rise on line 4", v, 32'h10);
    check("R10 no wake for disabled line", {31'b0, wakeReq}, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule